// File: doc/BRIEF.md
# Checksummed I2C Register Access Master

This block is an I2C master that carries out exactly one 16-bit register transfer per command. The target device is addressed with a 7-bit bus address. The register is selected by a 15-bit register number that travels in two bytes. A checksum byte protects each transfer. SCL and SDA are treated as open-drain lines. The block pulls a line low through an output enable and observes the real line level through a separate input.

A command is taken when `cmd_valid` is high and the block is idle. A read sends the register number and its checksum, issues a repeated start, and collects two data bytes and a trailing checksum byte. A write sends the register number, both data bytes and the checksum. When an attempt fails, the block clears the bus and tries again, within a fixed budget for each direction. The outcome is reported with a one-cycle `done` pulse, a held `err` level and, for reads, `rdata`.

Top module: `i2c_csum_master`

## Requirements
- R1: The first register byte is register bits 14:8 in byte bits 7:1, with bit 0 = 1 for a read and 0 for a write. The second register byte is register bits 7:0. The address byte is the 7-bit device address in bits 7:1, with bit 0 = 0 for write and 1 for read.
- R2: The checksum byte is the inverse of an 8-bit sum in which every carry out of bit 7 is folded back into bit 0. The sum covers both register bytes for a read, and both register bytes plus data high then data low for a write.
- R3: A write attempt is: start, address(write), register high, register low, data high, data low, checksum, stop. The slave must acknowledge every byte.
- R4: A read attempt is: start, address(write), register high, register low, checksum, repeated start, address(read), then three received bytes. The master acknowledges the first two received bytes, leaves the third unacknowledged, and then sends stop.
- R5: `rdata` becomes {first received byte, second received byte} on a successful read. The received checksum byte is not checked. `rdata` is unchanged by writes and by failed reads.
- R6: A missing acknowledge ends the attempt. A read is tried at most `RD_TRIES` (4) times and a write at most `WR_TRIES` (2) times. If the final attempt fails, `err` is 1 together with `done`; otherwise `err` is 0.
- R7: After every failed attempt, and before any retry or final report, the master gives nine SCL pulses with SDA released, then a start, then a stop.
- R8: Bytes are sent MSB first. SDA changes only while SCL is low, except at start and stop conditions.
- R9: SCL is held low for at least ceil(CLK_HZ*T_LOW_NS/1e9) cycles and is high for at least ceil(CLK_HZ*T_HIGH_NS/1e9) cycles.
- R10: If SCL stays low for `STRETCH_CYC` cycles after being released, the attempt fails. A timeout during the bus clear ends the command at once with `err` = 1.
- R11: When the master releases SDA expecting a 1 (a start condition or a 1 data bit of a sent byte) and SDA reads 0, the attempt fails.
- R12: `done` is a single-cycle pulse. `cmd_valid` is ignored while `busy`. Both output enables are deasserted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a transfer (taken only when idle) |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_dev | input | 7 | Device bus address |
| cmd_reg | input | 15 | Register number |
| cmd_wdata | input | 16 | Data to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command failed (valid from `done` until next command) |
| rdata | output | 16 | Data of the last successful read |
| scl_i | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions check, every cycle, that SDA never moves while SCL is high outside a start or stop edge, and that `done` lasts exactly one cycle. They also check that the attempt count stays within its budget, that a rising `err` comes with `done`, and that an idle master leaves both lines free. The following can only be shown by the bench's slave scenarios, which inject acknowledge failures, a stuck SDA and a held SCL: the byte contents and order of each frame, the checksum arithmetic, the exact pulse count of each bus clear, the retry totals, the returned data and the minimum SCL phase widths.

// File: rtl/i2c_csum_master.sv
module i2c_csum_master #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int T_HIGH_NS   = 4000,
  parameter int T_LOW_NS    = 4700,
  parameter int STRETCH_CYC = 4096,
  parameter int RD_TRIES    = 4,
  parameter int WR_TRIES    = 2
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_rd,
  input  logic [6:0]  cmd_dev,
  input  logic [14:0] cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata,
  input  logic        scl_i,
  output logic        scl_oe,
  input  logic        sda_i,
  output logic        sda_oe
);
  localparam longint NS_S   = 1_000_000_000;
  localparam int HC_RAW     = int'((longint'(CLK_HZ) * T_HIGH_NS + NS_S - 1) / NS_S);
  localparam int LC_RAW     = int'((longint'(CLK_HZ) * T_LOW_NS + NS_S - 1) / NS_S);
  localparam int HC         = (HC_RAW < 2) ? 2 : HC_RAW;
  localparam int LC         = (LC_RAW < 2) ? 2 : LC_RAW;
  localparam int CMAX       = (STRETCH_CYC > HC) ? ((STRETCH_CYC > LC) ? STRETCH_CYC : LC) : ((HC > LC) ? HC : LC);
  localparam int CW         = $clog2(CMAX + 1);
  localparam int TMAX       = (RD_TRIES > WR_TRIES) ? RD_TRIES : WR_TRIES;
  localparam int TW         = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_RISE, S_HIGH, S_EDGE} st_t;
  typedef enum logic [2:0] {K_START, K_STOP, K_WR, K_RD, K_PULSE} kind_t;

  st_t         st;
  kind_t       kind;
  logic [CW-1:0] cnt;
  logic [3:0]  step, bitn;
  logic [TW-1:0] tries;
  logic        rec, rd_q, sda_q;
  logic [6:0]  dev_q;
  logic [14:0] reg_q;
  logic [15:0] wd_q;
  logic [7:0]  rx, hi_q, lo_q, tx;

  function automatic logic [7:0] oc_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  logic [7:0] rh, rl, cs_rd, cs_wr;
  assign rh    = {reg_q[14:8], rd_q};
  assign rl    = reg_q[7:0];
  assign cs_rd = ~oc_add(rh, rl);
  assign cs_wr = ~oc_add(oc_add(oc_add(rh, rl), wd_q[15:8]), wd_q[7:0]);

  always_comb begin
    if (rec)       kind = (step < 4'd9) ? K_PULSE : ((step == 4'd9) ? K_START : K_STOP);
    else if (rd_q)
      case (step)
        4'd0, 4'd5:                   kind = K_START;
        4'd1, 4'd2, 4'd3, 4'd4, 4'd6: kind = K_WR;
        4'd7, 4'd8, 4'd9:             kind = K_RD;
        default:                      kind = K_STOP;
      endcase
    else
      case (step)
        4'd0:                                 kind = K_START;
        4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6:   kind = K_WR;
        default:                              kind = K_STOP;
      endcase
  end

  always_comb
    case (step)
      4'd1:    tx = {dev_q, 1'b0};
      4'd2:    tx = rh;
      4'd3:    tx = rl;
      4'd4:    tx = rd_q ? cs_rd : wd_q[15:8];
      4'd5:    tx = wd_q[7:0];
      4'd6:    tx = rd_q ? {dev_q, 1'b1} : cs_wr;
      default: tx = 8'h00;
    endcase

  logic [2:0] bsel;
  logic last_bit, tx_bit, sda_rel, hi_end, edge_end, want_one, nack, tmo, fail;
  logic [TW-1:0] limit;
  assign bsel     = 3'd7 - bitn[2:0];
  assign last_bit = (bitn == 4'd8);
  assign tx_bit   = tx[bsel];
  assign limit    = rd_q ? TW'(RD_TRIES) : TW'(WR_TRIES);

  always_comb
    case (kind)
      K_START: sda_rel = (st != S_EDGE);
      K_STOP:  sda_rel = (st == S_EDGE);
      K_WR:    sda_rel = last_bit | tx_bit;
      K_RD:    sda_rel = !last_bit | (step == 4'd9);
      default: sda_rel = 1'b1;
    endcase

  assign hi_end   = (st == S_HIGH) && (cnt == CW'(HC - 1));
  assign edge_end = (st == S_EDGE) && (cnt == CW'(HC - 1));
  assign want_one = !rec && ((kind == K_START) || (kind == K_WR && !last_bit && tx_bit));
  assign nack     = !rec && (kind == K_WR) && last_bit && sda_i;
  assign tmo      = (st == S_RISE) && !scl_i && (cnt == CW'(STRETCH_CYC - 1));
  assign fail     = tmo || (hi_end && ((want_one && !sda_i) || nack));

  assign scl_oe = (st == S_LOW);
  assign sda_oe = sda_q;
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; step <= '0; bitn <= '0; tries <= '0;
      rec <= 1'b0; rd_q <= 1'b0; sda_q <= 1'b0; dev_q <= '0; reg_q <= '0; wd_q <= '0;
      rx <= '0; hi_q <= '0; lo_q <= '0; done <= 1'b0; err <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE || st == S_LOW || st == S_EDGE) sda_q <= (st != S_IDLE) && !sda_rel;
      case (st)
        S_IDLE: if (cmd_valid) begin
          rd_q <= cmd_rd; dev_q <= cmd_dev; reg_q <= cmd_reg; wd_q <= cmd_wdata;
          tries <= '0; rec <= 1'b0; step <= '0; bitn <= '0; cnt <= '0; err <= 1'b0;
          st <= S_LOW;
        end
        S_LOW: if (cnt == CW'(LC - 1)) begin cnt <= '0; st <= S_RISE; end
               else cnt <= cnt + 1'b1;
        S_RISE: if (scl_i) begin cnt <= '0; st <= S_HIGH; end
                else cnt <= cnt + 1'b1;
        S_HIGH: if (hi_end) begin
          cnt <= '0;
          if (kind == K_RD && !last_bit) begin
            rx <= {rx[6:0], sda_i};
            if (bitn == 4'd7 && step == 4'd7) hi_q <= {rx[6:0], sda_i};
            if (bitn == 4'd7 && step == 4'd8) lo_q <= {rx[6:0], sda_i};
          end
          if (kind == K_START || kind == K_STOP) st <= S_EDGE;
          else if ((kind == K_WR || kind == K_RD) && !last_bit) begin
            bitn <= bitn + 1'b1; st <= S_LOW;
          end else begin
            bitn <= '0; step <= step + 1'b1; st <= S_LOW;
          end
        end else cnt <= cnt + 1'b1;
        S_EDGE: if (edge_end) begin
          cnt <= '0;
          if (kind != K_STOP) begin
            bitn <= '0; step <= step + 1'b1; st <= S_LOW;
          end else if (!rec) begin
            done <= 1'b1; st <= S_IDLE;
            if (rd_q) rdata <= {hi_q, lo_q};
          end else if (tries == limit) begin
            done <= 1'b1; err <= 1'b1; st <= S_IDLE;
          end else begin
            rec <= 1'b0; step <= '0; bitn <= '0; st <= S_LOW;
          end
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
      if (fail) begin
        cnt <= '0; step <= '0; bitn <= '0;
        if (!rec) begin
          tries <= tries + 1'b1; rec <= 1'b1; st <= S_LOW;
        end else begin
          done <= 1'b1; err <= 1'b1; sda_q <= 1'b0; st <= S_IDLE;
        end
      end
    end

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && scl_i && st != S_EDGE) |-> $stable(sda_oe)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!scl_oe && !sda_oe)); // R12
  AST_TRIES_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tries <= limit)); // R6
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done); // R6
endmodule

// File: tb/tb_i2c_csum_master.sv
module tb_i2c_csum_master;
  localparam int CLK_HZ = 2_500_000;
  localparam int STR    = 64;
  localparam int LOWC   = 12;
  localparam int HIGHC  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rd = 1'b0;
  logic [6:0] cmd_dev = '0;
  logic [14:0] cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, done, err, scl_oe, sda_oe;
  logic [15:0] rdata;
  logic sl_sda_low = 1'b0, sl_stuck = 1'b0, sl_scl_hold = 1'b0;
  wire scl = !(scl_oe || sl_scl_hold);
  wire sda = !(sda_oe || sl_sda_low || sl_stuck);

  i2c_csum_master #(.CLK_HZ(CLK_HZ), .STRETCH_CYC(STR)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_dev(cmd_dev),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .scl_i(scl), .scl_oe(scl_oe), .sda_i(sda), .sda_oe(sda_oe));

  initial forever #4 clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model state
  logic ps = 1'b1, pd = 1'b1, first = 1'b0, rd_seg = 1'b0, nk;
  int smode = 0, bc = 0, attempts = 0, fail_k = 0, nrx = 0, txi = 0;
  int rises = 0, starts = 0, stops = 0, run = 0, min_hi = 1000000, min_lo = 1000000;
  bit seen_edge = 0;
  logic [7:0] sh = '0;
  logic [7:0] rx_log [16];
  logic [7:0] txb [3];
  logic macks [3];

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (ps && scl && pd && !sda) begin
        starts++; smode = 1; bc = 0; first = 1'b1; sl_sda_low = 1'b0;
      end else if (ps && scl && !pd && sda) begin
        stops++; smode = 0; sl_sda_low = 1'b0;
      end else if (!ps && scl) begin
        rises++;
        if (smode == 1 && bc < 8) begin sh = {sh[6:0], sda}; bc++; end
        else if (smode == 2 && bc == 8) macks[txi] = !sda;
      end else if (ps && !scl) begin
        if (smode == 1) begin
          if (bc == 8) begin
            bc = 9; nk = 1'b0;
            if (first && !sh[0]) begin attempts++; nrx = 0; if (attempts <= fail_k) nk = 1'b1; end
            if (nrx < 16) rx_log[nrx] = sh;
            nrx++;
            rd_seg = first && sh[0]; first = 1'b0;
            sl_sda_low = !nk;
            if (nk) smode = 0;
          end else if (bc == 9) begin
            sl_sda_low = 1'b0; bc = 0;
            if (rd_seg) begin smode = 2; txi = 0; sl_sda_low = !txb[0][7]; end
          end
        end else if (smode == 2) begin
          bc++;
          if (bc < 8) sl_sda_low = !txb[txi][3'(7 - bc)];
          else if (bc == 8) sl_sda_low = 1'b0;
          else begin
            bc = 0;
            if (!macks[txi] || txi == 2) smode = 0;
            else begin txi++; sl_sda_low = !txb[txi][7]; end
          end
        end
      end
      if (scl == ps) run++;
      else begin
        if (seen_edge) begin
          if (ps && run < min_hi) min_hi = run;
          if (!ps && run < min_lo) min_lo = run;
        end
        seen_edge = 1; run = 1;
      end
    end
    ps = scl; pd = sda;
  end

  function automatic logic [7:0] ref_cs(input int total);
    int s = total;
    while (s > 255) s = (s & 255) + (s >> 8);
    return ~s[7:0];
  endfunction

  logic got_err;
  logic [15:0] got_data;
  int got_cyc;

  task automatic issue(input logic rd, input logic [6:0] dv, input logic [14:0] rg,
                       input logic [15:0] wd, input int fk, input bit poke);
    fail_k = fk; attempts = 0; nrx = 0; rises = 0; starts = 0; stops = 0;
    for (int i = 0; i < 3; i++) begin txb[i] = 8'($urandom); macks[i] = 1'bx; end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rd = rd; cmd_dev = dv; cmd_reg = rg; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_rd = ~rd; cmd_dev = ~dv; cmd_reg = ~rg; cmd_wdata = ~wd;
    got_cyc = 1;
    while (!done && got_cyc < 30000) begin
      if (poke && got_cyc == 300) cmd_valid = 1'b1;
      if (poke && got_cyc == 302) cmd_valid = 1'b0;
      @(negedge clk); got_cyc++;
    end
    cmd_valid = 1'b0;
    check("R12 done seen", {31'd0, done}, 32'd1);
    got_err = err; got_data = rdata;
  endtask

  task automatic run_good(input logic rd, input logic [6:0] dv, input logic [14:0] rg,
                          input logic [15:0] wd, input int fk, input bit poke);
    logic [7:0] rhb, rlb, csb;
    logic [15:0] prev = rdata;
    int budget = rd ? 4 : 2;
    rhb = {rg[14:8], rd}; rlb = rg[7:0];
    csb = rd ? ref_cs(rhb + rlb) : ref_cs(rhb + rlb + wd[15:8] + wd[7:0]);
    issue(rd, dv, rg, wd, fk, poke);
    if (fk < budget) begin
      check("R6 err clear", {31'd0, got_err}, 32'd0);
      check("R6 attempts", attempts, fk + 1);
      check("R7 scl pulses", rises, fk * 21 + (rd ? 75 : 56));
      check("R7 starts", starts, fk * 2 + (rd ? 2 : 1));
      check("R7 stops", stops, fk + 1);
      check("R1 addr byte", rx_log[0], {dv, 1'b0});
      check("R1 reg high", rx_log[1], rhb);
      check("R1 reg low", rx_log[2], rlb);
      if (rd) begin
        check("R4 byte count", nrx, 5);
        check("R2 read checksum", rx_log[3], csb);
        check("R4 read addr", rx_log[4], {dv, 1'b1});
        check("R4 master acks", {29'd0, macks[0], macks[1], macks[2]}, 32'b110);
        check("R5 read data", got_data, {txb[0], txb[1]});
      end else begin
        check("R3 byte count", nrx, 6);
        check("R3 data high", rx_log[3], wd[15:8]);
        check("R3 data low", rx_log[4], wd[7:0]);
        check("R2 write checksum", rx_log[5], csb);
        check("R5 rdata kept", got_data, prev);
      end
    end else begin
      check("R6 err set", {31'd0, got_err}, 32'd1);
      check("R6 attempts max", attempts, budget);
      check("R7 scl pulses fail", rises, budget * 21);
      check("R5 rdata kept on fail", got_data, prev);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R12 reset busy", {31'd0, busy}, 32'd0);
    check("R12 reset lines", {30'd0, scl_oe, sda_oe}, 32'd0);
    check("R12 reset done/err", {30'd0, done, err}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run_good(1'b0, 7'h55, 15'h7FFF, 16'hFFFF, 0, 0);
    run_good(1'b1, 7'h2A, 15'h0000, 16'h0000, 0, 0);
    run_good(1'b1, 7'h01, 15'h1234, 16'h0000, 3, 0);
    run_good(1'b1, 7'h01, 15'h4321, 16'h0000, 4, 0);
    run_good(1'b0, 7'h7F, 15'h0180, 16'h8001, 1, 0);
    run_good(1'b0, 7'h7F, 15'h0180, 16'h8001, 2, 0);
    run_good(1'b1, 7'h33, 15'h5A5A, 16'h0000, 0, 1);
    repeat (40) @(negedge clk);
    check("R12 poke ignored, idle", {31'd0, busy}, 32'd0);

    sl_stuck = 1'b1;
    issue(1'b0, 7'h10, 15'h0010, 16'h1234, 0, 0);
    check("R11 stuck sda err", {31'd0, got_err}, 32'd1);
    check("R11 stuck sda pulses", rises, 24);
    sl_stuck = 1'b0;
    repeat (20) @(negedge clk);

    sl_scl_hold = 1'b1;
    issue(1'b1, 7'h10, 15'h0010, 16'h0000, 0, 0);
    check("R10 timeout err", {31'd0, got_err}, 32'd1);
    check("R10 no scl rise", rises, 0);
    check("R10 quick abort", {31'd0, got_cyc <= 2 * (LOWC + STR) + 20}, 32'd1);
    sl_scl_hold = 1'b0;
    repeat (20) @(negedge clk);

    for (int n = 0; n < 10; n++) begin
      logic r = 1'($urandom);
      run_good(r, 7'($urandom), 15'($urandom), 16'($urandom), $urandom_range(0, r ? 3 : 1), 0);
    end

    check("R9 min scl high", {31'd0, min_hi >= HIGHC}, 32'd1);
    check("R9 min scl low", {31'd0, min_lo >= LOWC}, 32'd1);
    check("R8 msb-first frames (random)", {31'd0, seen_edge}, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial forever begin
    @(posedge clk); cyc++;
    if (cyc > 190000) begin
      vectors++; miscompares++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule